// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single start request into the ordered list of column addresses that one memory burst visits. The requester presents a starting column, a burst length code (2, 4 or 8 beats) and a burst type (sequential or interleaved) together with a one-cycle start strobe. The block then puts out one column address per clock, with a valid flag on every beat and a last flag on the final beat.

The burst length fixes an aligned block of 2, 4 or 8 columns. Only the low offset bits inside that block move during the burst, and they never carry into the bits above. Sequential bursts count the offset upward and wrap at the block edge. Interleaved bursts XOR the beat index with the starting offset. All column bits above the in-block offset are copied unchanged onto every beat.

The controller is a two-state machine. IDLE waits for a start. The transition IDLE->BURST is taken on a clock edge where start is high; it captures the column, length and type. BURST stays in BURST while beats remain. The transition BURST->IDLE is taken on the edge that retires the beat flagged last.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid_o and beat_last_o are low, and they stay low until a start is accepted.
- R2: A start seen high on a clock edge while IDLE makes the first beat appear on the outputs in the following cycle. The burst then delivers exactly 2, 4 or 8 consecutive valid beats, and valid drops in the cycle after the last beat.
- R3: beat_last_o is high only on the final beat of a burst and only while beat_valid_o is high.
- R4: The length code on burst_len_i is 2'b00 for 2 beats, 2'b01 for 4 beats and 2'b10 for 8 beats. The code 2'b11 is treated as 8 beats. The low 1, 2 or 3 column bits are the in-block offset.
- R5: With burst_type_i = 0 (sequential), beat i carries offset (start_offset + i) modulo the burst length. For example, start 2 at length 4 gives 2-3-0-1.
- R6: With burst_type_i = 1 (interleaved), beat i carries offset start_offset XOR i. For example, start 6 at length 8 gives 6-7-4-5-2-3-0-1.
- R7: Column bits above the in-block offset equal the starting column's bits on every beat; the offset never carries into them.
- R8: A start asserted while a burst is in progress, including on its last beat, is ignored. The running burst continues unchanged, and no new burst begins after it.
- R9: Column, length and type are sampled only when a start is accepted. Changes on those inputs during a burst do not alter its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, acted on only in IDLE |
| start_col_i | input | COL_W | Starting column address |
| burst_len_i | input | 2 | Length code: 00=2, 01=4, 10/11=8 beats |
| burst_type_i | input | 1 | 0 = sequential, 1 = interleaved |
| beat_valid_o | output | 1 | A beat address is present |
| beat_last_o | output | 1 | Present beat is the final one |
| beat_col_o | output | COL_W | Column address of the present beat |

## Verification
Beat k of a burst is on the outputs from the k-th clock edge after the edge that accepted the start. The registered state and beat counter feed the address logic combinationally, so there is no further delay. The bench drives inputs on falling edges and reads each beat on the falling edge that follows its rising edge. It checks address, valid and last against an arithmetic model of both orders. One cycle after the last beat it checks that valid has dropped, even though start is still held high. Every start offset is swept with two upper-bit patterns, both types and all four length codes. In every burst, start is held high from the second beat onward while the column, length and type inputs are changed to other values.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Width of the in-block offset for the longest burst (8 beats).
    localparam int BCS_OFF_W = 3;

    typedef enum logic [1:0] {
        LEN_2  = 2'b00,
        LEN_4  = 2'b01,
        LEN_8  = 2'b10,
        LEN_8X = 2'b11
    } burst_len_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } burst_ord_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

    // Offset mask selected by the length code.
    function automatic logic [BCS_OFF_W-1:0] len_to_mask(input burst_len_e len);
        logic [BCS_OFF_W-1:0] m;
        unique case (len)
            LEN_2:         m = BCS_OFF_W'(1);
            LEN_4:         m = BCS_OFF_W'(3);
            LEN_8, LEN_8X: m = BCS_OFF_W'(7);
            default:       m = BCS_OFF_W'(7);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcs_offset_gen.sv
module bcs_offset_gen
    import bcs_pkg::*;
(
    input  logic [BCS_OFF_W-1:0] start_off_i,
    input  logic [BCS_OFF_W-1:0] beat_idx_i,
    input  logic [BCS_OFF_W-1:0] mask_i,
    input  burst_ord_e           order_i,
    output logic [BCS_OFF_W-1:0] off_o
);

    logic [BCS_OFF_W-1:0] seq_off;
    logic [BCS_OFF_W-1:0] xor_off;

    // The mask drops any carry out of the block, giving the wrap.
    assign seq_off = (start_off_i + beat_idx_i) & mask_i;
    assign xor_off = (start_off_i ^ beat_idx_i) & mask_i;

    always_comb begin
        unique case (order_i)
            ORD_SEQ: off_o = seq_off;
            ORD_XOR: off_o = xor_off;
            default: off_o = seq_off;
        endcase
    end

endmodule

// File: rtl/bcs_addr_merge.sv
module bcs_addr_merge
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]     base_col_i,
    input  logic [BCS_OFF_W-1:0] off_i,
    input  logic [BCS_OFF_W-1:0] mask_i,
    output logic [COL_W-1:0]     col_o
);

    genvar g;
    generate
        for (g = 0; g < COL_W; g++) begin : g_bit
            if (g < BCS_OFF_W) begin : g_low
                assign col_o[g] = mask_i[g] ? off_i[g] : base_col_i[g];
            end else begin : g_high
                assign col_o[g] = base_col_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [COL_W-1:0]     start_col_i,
    input  logic [1:0]           burst_len_i,
    input  logic                 burst_type_i,
    output logic [COL_W-1:0]     base_col_o,
    output logic [BCS_OFF_W-1:0] beat_idx_o,
    output logic [BCS_OFF_W-1:0] mask_o,
    output burst_ord_e           order_o,
    output logic                 valid_o,
    output logic                 last_o
);

    seq_state_e           state_q, state_d;
    logic [BCS_OFF_W-1:0] beat_q;
    logic [BCS_OFF_W-1:0] mask_q;
    logic [COL_W-1:0]     col_q;
    burst_ord_e           ord_q;
    logic                 on_final;
    logic                 accept;

    assign on_final = (state_q == ST_BURST) && (beat_q == mask_q);
    assign accept   = (state_q == ST_IDLE) && start_i;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)  state_d = ST_BURST;
            ST_BURST: if (on_final) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst context: captured on accept, beat counter advanced in BURST.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            mask_q <= '0;
            col_q  <= '0;
            ord_q  <= ORD_SEQ;
        end else if (accept) begin
            beat_q <= '0;
            mask_q <= len_to_mask(burst_len_e'(burst_len_i));
            col_q  <= start_col_i;
            ord_q  <= burst_ord_e'(burst_type_i);
        end else if (state_q == ST_BURST) begin
            beat_q <= beat_q + BCS_OFF_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        valid_o    = 1'b0;
        last_o     = 1'b0;
        base_col_o = col_q;
        beat_idx_o = beat_q;
        mask_o     = mask_q;
        order_o    = ord_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                valid_o = 1'b1;
                last_o  = on_final;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       burst_len_i,
    input  logic             burst_type_i,
    output logic             beat_valid_o,
    output logic             beat_last_o,
    output logic [COL_W-1:0] beat_col_o
);

    logic [COL_W-1:0]     base_col;
    logic [BCS_OFF_W-1:0] beat_idx;
    logic [BCS_OFF_W-1:0] mask;
    logic [BCS_OFF_W-1:0] off;
    burst_ord_e           order;

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .burst_len_i  (burst_len_i),
        .burst_type_i (burst_type_i),
        .base_col_o   (base_col),
        .beat_idx_o   (beat_idx),
        .mask_o       (mask),
        .order_o      (order),
        .valid_o      (beat_valid_o),
        .last_o       (beat_last_o)
    );

    bcs_offset_gen u_off (
        .start_off_i (base_col[BCS_OFF_W-1:0]),
        .beat_idx_i  (beat_idx),
        .mask_i      (mask),
        .order_i     (order),
        .off_o       (off)
    );

    bcs_addr_merge #(.COL_W(COL_W)) u_merge (
        .base_col_i (base_col),
        .off_i      (off),
        .mask_i     (mask),
        .col_o      (beat_col_o)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             beat_valid_o,
    input logic             beat_last_o,
    input logic [COL_W-1:0] beat_col_o
);

    assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_valid_o);

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_last_o) |=> beat_valid_o);

    assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |=> !beat_valid_o);

    assert_begin_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid_o) |-> $past(start_i));

    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_last_o) |=> $stable(beat_col_o[COL_W-1:3]));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .beat_col_o   (beat_col_o)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       burst_len_i = 2'b00;
    logic             burst_type_i = 1'b0;
    logic             beat_valid_o;
    logic             beat_last_o;
    logic [COL_W-1:0] beat_col_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .burst_len_i  (burst_len_i),
        .burst_type_i (burst_type_i),
        .beat_valid_o (beat_valid_o),
        .beat_last_o  (beat_last_o),
        .beat_col_o   (beat_col_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One burst: start accepted, all beats checked, then idle checked.
    task automatic run_burst(input int col, input int len, input int typ);
        int nb;
        int base;
        int off0;
        int exp_col;
        nb   = (len == 0) ? 2 : (len == 1) ? 4 : 8;   // R4 length codes
        base = col & ~(nb - 1);
        off0 = col & (nb - 1);
        start_i      = 1'b1;
        start_col_i  = COL_W'(col);
        burst_len_i  = 2'(len);
        burst_type_i = typ[0];
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < nb; i++) begin
            if (typ == 0) exp_col = base | ((off0 + i) % nb);   // R5
            else          exp_col = base | (off0 ^ i);          // R6
            check("R2", "valid", int'(beat_valid_o), 1);
            check("R5/R6/R7", "column", int'(beat_col_o), exp_col);
            check("R3", "last", int'(beat_last_o), (i == nb - 1) ? 1 : 0);
            // R8/R9: hold start and scramble inputs mid-burst
            start_i      = 1'b1;
            start_col_i  = COL_W'(col ^ 10'h2A5);
            burst_len_i  = 2'(len ^ 1);
            burst_type_i = ~typ[0];
            @(negedge clk);
        end
        check("R8", "valid after last with start held", int'(beat_valid_o), 0);
        start_i = 1'b0;
        @(negedge clk);
        check("R2", "idle gap", int'(beat_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(beat_valid_o), 0);
        check("R1", "last in reset", int'(beat_last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "valid after reset", int'(beat_valid_o), 0);
        // Spot examples from R5 and R6 are covered by the sweep below.
        for (int len = 0; len < 4; len++)
            for (int typ = 0; typ < 2; typ++)
                for (int up = 0; up < 2; up++)
                    for (int off = 0; off < 8; off++)
                        run_burst((up ? 10'h358 : 10'h0A0) | off, len, typ);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule